// File: doc/BRIEF.md
# Randomized Transmit Delay Scheduler

This block decides when a passive identification tag sends its code. A delay counter advances on a bit-rate tick. It is compared with the output of a pseudo-random generator, using only a configurable number of low bits. When the two are equal, the block raises a one-cycle transmit-start request. In the same step it advances the generator and clears the counter, so the next wait has a new length. The compare width is set from a 3-bit selector and fixes the longest possible gap between two transmissions.

The block also reacts to reader commands. After a transmission ends, a short listen window opens, and an acknowledge in that window either halts the tag until reset or moves it into slowed counting. A mute puts the tag into a timed sleep, and the sleep restarts on every further mute. A wake-up ends the sleep at once. The transmitter's busy flag freezes the counter.

The state machine has six states: COUNT, LAUNCH, XMIT, LISTEN, SLEEP and OFF.
- COUNT to LAUNCH on a compare hit.
- LAUNCH to XMIT after one cycle.
- XMIT to LISTEN on transmit-done.
- LISTEN to OFF or back to COUNT on an accepted acknowledge. LISTEN to SLEEP on an accepted mute. LISTEN to COUNT when the window expires.
- COUNT to SLEEP on an accepted mute.
- SLEEP to COUNT on wake-up or when the sleep expires. SLEEP to SLEEP on a further mute, which restarts the sleep.
- OFF is left only by reset.

Top module: `txsched_top`

## Requirements
- R1: Reset places the block in COUNT with the delay counter at 0 and all outputs low. The generator is loaded from `seed`, and a zero seed is replaced by 1.
- R2: The generator is a 16-bit shift-left register. Each step computes the new bit 0 as the XOR of bits 15, 14, 12 and 3. It steps exactly once per transmit start and never holds zero.
- R3: The compare uses the low 9+`width_sel` bits. `tx_start` appears after (random AND mask)+1 qualifying ticks counted from a cleared counter. A selector value of 7 compares all 16 bits.
- R4: `tx_start` is high for exactly one cycle. The counter then stays cleared through transmission and through a 16-tick listen window that starts at `tx_done`. Counting resumes after the window.
- R5: A tick that arrives while `tx_busy` is high does not advance the counter.
- R6: An acknowledge inside the listen window, with `ack_en`=1 and `ack_off`=1, sets `halted`. The block stays halted until reset and issues no further `tx_start`.
- R7: An acknowledge inside the listen window, with `ack_en`=1 and `ack_off`=0, sets `slow_mode` until reset and ends the window. From then on only one tick in 8 qualifies, so the delay becomes 8×((random AND mask)+1) ticks.
- R8: An acknowledge has no effect when `ack_en`=0 or when it arrives outside the listen window.
- R9: A mute with `mute_en`=1, received in COUNT or LISTEN, raises `asleep` for 128 ticks. The delay counter holds its value during the sleep and resumes from it afterwards.
- R10: A mute with `mute_en`=1 during sleep restarts the 128-tick sleep from zero.
- R11: A wake-up pulse during sleep clears `asleep` on the next cycle. It takes priority over a mute in the same cycle.
- R12: A mute has no effect when `mute_en`=0, and none during LAUNCH or XMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle bit-rate tick |
| width_sel | input | 3 | Compare width selector, width = 9 + value |
| ack_en | input | 1 | Enables the reaction to acknowledge |
| ack_off | input | 1 | 1: an acknowledge halts the block; 0: an acknowledge slows it |
| mute_en | input | 1 | Enables the reaction to mute |
| seed | input | 16 | Generator load value at reset |
| tx_busy | input | 1 | Transmitter busy; freezes the counter |
| tx_done | input | 1 | Pulse marking the end of a transmission |
| ack_pulse | input | 1 | Acknowledge command pulse |
| mute_pulse | input | 1 | Mute command pulse |
| wake_pulse | input | 1 | Wake-up command pulse |
| tx_start | output | 1 | One-cycle transmit request |
| asleep | output | 1 | High while sleeping |
| halted | output | 1 | High once shut off by an acknowledge |
| slow_mode | output | 1 | High once slowed counting is active |

## Verification
A corrupted delay counter, generator or prescaler shows up as a `tx_start` on the wrong tick. The bench predicts that tick exactly for every transmission, so the error is visible within one delay period. Each later period shows it again, because the expected random sequence runs independently of the design. A wrong sleep or listen timer moves the falling edge of `asleep`, or the following `tx_start`, away from its predicted tick within 128 or 16 ticks. A wrong OFF or slowed state shows on `halted` or `slow_mode` one cycle after the acknowledge.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
    typedef enum logic [2:0] {
        ST_COUNT  = 3'd0,
        ST_LAUNCH = 3'd1,
        ST_XMIT   = 3'd2,
        ST_LISTEN = 3'd3,
        ST_SLEEP  = 3'd4,
        ST_OFF    = 3'd5
    } sched_state_t;
endpackage

// File: rtl/txsched_lfsr.sv
module txsched_lfsr #(
    parameter int            W        = 16,
    parameter logic [W-1:0]  TAP_MASK = 16'hD008
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] q
);
    logic fb;

    assign fb = ^(q & TAP_MASK);

    // Shift-left register; a zero seed would lock it, so substitute 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= (seed == '0) ? W'(1) : seed;
        end else if (step) begin
            q <= {q[W-2:0], fb};
        end
    end
endmodule

// File: rtl/txsched_timer.sv
module txsched_timer #(
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic active,
    input  logic tick,
    output logic done
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign done = active & tick & (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (active && tick) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/txsched_delay.sv
module txsched_delay #(
    parameter int W     = 16,
    parameter int SEL_W = 3,
    parameter int DIV   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             busy,
    input  logic             slow,
    input  logic             slow_set,
    input  logic [SEL_W-1:0] width_sel,
    input  logic [W-1:0]     rnd,
    output logic             hit
);
    localparam int MIN_W = W - (1 << SEL_W) + 1;
    localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [W-1:0]     cnt_q;
    logic [DIV_W-1:0] div_q;
    logic [W-1:0]     mask;
    logic             step;
    logic             qual;
    logic             div_wrap;

    // Low-bit compare mask: 9..16 ones for the default parameters.
    always_comb begin
        for (int b = 0; b < W; b++) begin
            mask[b] = (b < (MIN_W + int'(width_sel)));
        end
    end

    assign step     = run & tick & ~busy;
    assign div_wrap = (div_q == DIV_W'(DIV - 1));
    assign qual     = step & (~slow | div_wrap);
    assign hit      = qual & (((cnt_q ^ rnd) & mask) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (slow_set) begin
            div_q <= '0;
        end else if (step && slow) begin
            div_q <= div_wrap ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q <= '0;
        end else if (qual) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/txsched_top.sv
module txsched_top
    import txsched_pkg::*;
#(
    parameter int                CNT_W        = 16,
    parameter int                SEL_W        = 3,
    parameter logic [CNT_W-1:0]  TAP_MASK     = 16'hD008,
    parameter int                SLOW_DIV     = 8,
    parameter int                SLEEP_TICKS  = 128,
    parameter int                LISTEN_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic [SEL_W-1:0] width_sel,
    input  logic             ack_en,
    input  logic             ack_off,
    input  logic             mute_en,
    input  logic [CNT_W-1:0] seed,
    input  logic             tx_busy,
    input  logic             tx_done,
    input  logic             ack_pulse,
    input  logic             mute_pulse,
    input  logic             wake_pulse,
    output logic             tx_start,
    output logic             asleep,
    output logic             halted,
    output logic             slow_mode
);
    sched_state_t     state_q, state_d;
    logic             slow_q;
    logic [CNT_W-1:0] rnd_q;
    logic             hit;
    logic             mute_ok, ack_ok;
    logic             run;
    logic             slow_set;
    logic             sleep_restart, sleep_done;
    logic             listen_restart, listen_done;

    assign mute_ok        = mute_pulse & mute_en;
    assign ack_ok         = ack_pulse & ack_en;
    assign run            = (state_q == ST_COUNT) & ~mute_ok;
    assign slow_set       = (state_q == ST_LISTEN) & ack_ok & ~ack_off;
    assign sleep_restart  = mute_ok & (state_d == ST_SLEEP);
    assign listen_restart = (state_q == ST_XMIT) & tx_done;

    txsched_lfsr #(.W(CNT_W), .TAP_MASK(TAP_MASK)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (seed),
        .step  (hit),
        .q     (rnd_q)
    );

    txsched_delay #(.W(CNT_W), .SEL_W(SEL_W), .DIV(SLOW_DIV)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (bit_tick),
        .busy      (tx_busy),
        .slow      (slow_q),
        .slow_set  (slow_set),
        .width_sel (width_sel),
        .rnd       (rnd_q),
        .hit       (hit)
    );

    txsched_timer #(.LIMIT(SLEEP_TICKS)) u_sleep_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sleep_restart),
        .active  (state_q == ST_SLEEP),
        .tick    (bit_tick),
        .done    (sleep_done)
    );

    txsched_timer #(.LIMIT(LISTEN_TICKS)) u_listen_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (listen_restart),
        .active  (state_q == ST_LISTEN),
        .tick    (bit_tick),
        .done    (listen_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (mute_ok)  state_d = ST_SLEEP;
                else if (hit) state_d = ST_LAUNCH;
            end
            ST_LAUNCH: state_d = ST_XMIT;
            ST_XMIT: begin
                if (tx_done) state_d = ST_LISTEN;
            end
            ST_LISTEN: begin
                if (ack_ok)           state_d = ack_off ? ST_OFF : ST_COUNT;
                else if (mute_ok)     state_d = ST_SLEEP;
                else if (listen_done) state_d = ST_COUNT;
            end
            ST_SLEEP: begin
                if (wake_pulse)      state_d = ST_COUNT;
                else if (mute_ok)    state_d = ST_SLEEP;
                else if (sleep_done) state_d = ST_COUNT;
            end
            ST_OFF:  state_d = ST_OFF;
            default: state_d = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            slow_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (slow_set) slow_q <= 1'b1;
        end
    end

    always_comb begin
        tx_start  = (state_q == ST_LAUNCH);
        asleep    = (state_q == ST_SLEEP);
        halted    = (state_q == ST_OFF);
        slow_mode = slow_q;
    end
endmodule

// File: rtl/txsched_chk.sv
module txsched_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             tx_busy,
    input logic             mute_pulse,
    input logic             mute_en,
    input logic             wake_pulse,
    input logic             tx_start,
    input logic             asleep,
    input logic             halted,
    input logic             slow_mode,
    input logic [CNT_W-1:0] rnd
);
    AST_RND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != '0); // R2
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start); // R4
    AST_START_AFTER_FREE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_start) |-> $past(bit_tick && !tx_busy)); // R5
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !tx_start)); // R6
    AST_SLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        slow_mode |=> slow_mode); // R7
    AST_NO_START_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !tx_start); // R9
    AST_SLEEP_NEEDS_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(mute_pulse && mute_en)); // R12
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && wake_pulse) |=> !asleep); // R11
endmodule

bind txsched_top txsched_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .tx_busy    (tx_busy),
    .mute_pulse (mute_pulse),
    .mute_en    (mute_en),
    .wake_pulse (wake_pulse),
    .tx_start   (tx_start),
    .asleep     (asleep),
    .halted     (halted),
    .slow_mode  (slow_mode),
    .rnd        (rnd_q)
);

// File: tb/txsched_top_tb.sv
module txsched_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic [2:0]  width_sel = 3'd0;
    logic        ack_en = 1'b0;
    logic        ack_off = 1'b0;
    logic        mute_en = 1'b0;
    logic [15:0] seed = 16'h0001;
    logic        tx_busy = 1'b0;
    logic        tx_done = 1'b0;
    logic        ack_pulse = 1'b0;
    logic        mute_pulse = 1'b0;
    logic        wake_pulse = 1'b0;
    logic        tx_start, asleep, halted, slow_mode;

    int checks = 0;
    int errors = 0;
    logic [15:0] rnd_m;

    txsched_top u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .width_sel(width_sel),
        .ack_en(ack_en), .ack_off(ack_off), .mute_en(mute_en), .seed(seed),
        .tx_busy(tx_busy), .tx_done(tx_done), .ack_pulse(ack_pulse),
        .mute_pulse(mute_pulse), .wake_pulse(wake_pulse), .tx_start(tx_start),
        .asleep(asleep), .halted(halted), .slow_mode(slow_mode)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] lfsr_next(input logic [15:0] q);
        return {q[14:0], q[15] ^ q[14] ^ q[12] ^ q[3]};
    endfunction

    function automatic int exp_delay(input logic [15:0] r, input int ws);
        int m;
        m = (ws >= 7) ? 32'hFFFF : ((1 << (9 + ws)) - 1);
        return (int'(r) & m) + 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] s, input int ws);
        @(negedge clk);
        rst_n = 1'b0;
        seed = s;
        width_sel = 3'(ws);
        ack_en = 1'b0; ack_off = 1'b0; mute_en = 1'b0;
        tx_busy = 1'b0; tx_done = 1'b0; bit_tick = 1'b0;
        ack_pulse = 1'b0; mute_pulse = 1'b0; wake_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rnd_m = (s == 16'h0) ? 16'h0001 : s;
        @(negedge clk);
    endtask

    task automatic tick_once();
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    // 0 = ack, 1 = mute, 2 = wake, 3 = mute+wake, 4 = tx_done
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ack_pulse = 1'b1;
            1: mute_pulse = 1'b1;
            2: wake_pulse = 1'b1;
            3: begin mute_pulse = 1'b1; wake_pulse = 1'b1; end
            default: tx_done = 1'b1;
        endcase
        @(negedge clk);
        ack_pulse = 1'b0; mute_pulse = 1'b0; wake_pulse = 1'b0; tx_done = 1'b0;
    endtask

    task automatic measure(input int limit, output int n);
        bit found = 1'b0;
        n = 0;
        while (!found && n < limit) begin
            tick_once();
            n++;
            if (tx_start) found = 1'b1;
        end
        if (!found) n = -1;
        else rnd_m = lfsr_next(rnd_m);
    endtask

    task automatic ticks_no_start(input int k, output int starts);
        starts = 0;
        for (int i = 0; i < k; i++) begin
            tick_once();
            if (tx_start) starts++;
        end
    endtask

    // After a start: verify pulse width, finish the transmission, pass the listen window.
    task automatic close_tx(input string tag, input bit skip_window);
        int s;
        @(negedge clk);
        chk(tx_start == 1'b0, tag, int'(tx_start), 0);
        pulse(4);
        if (!skip_window) begin
            ticks_no_start(16, s);
            chk(s == 0, {tag, " listen window"}, s, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, e, s;
        logic [15:0] seeds [2];
        seeds[0] = 16'hACE1;
        seeds[1] = 16'h1357;

        // R1: reset state and zero-seed substitution
        do_reset(16'h0000, 0);
        chk(tx_start == 0 && asleep == 0 && halted == 0 && slow_mode == 0,
            "R1 reset outputs", {tx_start, asleep, halted, slow_mode}, 0);
        measure(4000, n);
        chk(n == 2, "R1 zero seed becomes 1", n, 2);

        // R2 R3 R4: sweep widths 9..11 with several seeds and transmissions
        for (int ws = 0; ws < 3; ws++) begin
            for (int si = 0; si < 2; si++) begin
                do_reset(seeds[si], ws);
                for (int t = 0; t < 3; t++) begin
                    e = exp_delay(rnd_m, ws);
                    measure(5000, n);
                    chk(n == e, "R2 R3 sweep delay", n, e);
                    close_tx("R4 single-cycle start", 1'b0);
                end
            end
        end

        // R3: full 16-bit compare
        do_reset(16'h0203, 7);
        measure(1000, n);
        chk(n == 516, "R3 full width", n, 516);
        do_reset(16'h0203, 0);
        measure(1000, n);
        chk(n == 4, "R3 narrow width", n, 4);

        // R5: busy freezes the counter
        do_reset(16'h0203, 0);
        tx_busy = 1'b1;
        ticks_no_start(10, s);
        chk(s == 0, "R5 busy no start", s, 0);
        tx_busy = 1'b0;
        measure(100, n);
        chk(n == 4, "R5 busy ticks ignored", n, 4);

        // R6: acknowledge shuts off
        do_reset(16'h0203, 0);
        measure(100, n);
        close_tx("R4 pulse", 1'b1);
        ticks_no_start(3, s);
        ack_en = 1'b1; ack_off = 1'b1;
        pulse(0);
        chk(halted == 1'b1, "R6 halted", int'(halted), 1);
        ticks_no_start(1200, s);
        chk(s == 0 && halted == 1'b1, "R6 no start while off", s, 0);

        // R7: acknowledge slows counting
        do_reset(16'h0203, 0);
        measure(100, n);
        close_tx("R4 pulse", 1'b1);
        ticks_no_start(2, s);
        ack_en = 1'b1; ack_off = 1'b0;
        pulse(0);
        chk(slow_mode == 1'b1 && halted == 1'b0, "R7 slow flag", int'(slow_mode), 1);
        e = 8 * exp_delay(rnd_m, 0);
        measure(5000, n);
        chk(n == e, "R7 slowed delay", n, e);

        // R8: acknowledge disabled, and acknowledge outside the window
        do_reset(16'h0203, 0);
        measure(100, n);
        close_tx("R4 pulse", 1'b1);
        ticks_no_start(2, s);
        ack_en = 1'b0; ack_off = 1'b1;
        pulse(0);
        chk(slow_mode == 0 && halted == 0, "R8 ack disabled", {slow_mode, halted}, 0);
        ticks_no_start(14, s);
        chk(s == 0, "R8 window still running", s, 0);
        ack_en = 1'b1; ack_off = 1'b0;
        pulse(0);
        chk(slow_mode == 0 && halted == 0, "R8 ack in COUNT ignored", {slow_mode, halted}, 0);
        e = exp_delay(rnd_m, 0);
        measure(1000, n);
        chk(n == e, "R8 normal delay after ack", n, e);

        // R9: mute sleeps 128 ticks, counter holds
        do_reset(16'h00C8, 0);
        mute_en = 1'b1;
        ticks_no_start(50, s);
        pulse(1);
        chk(asleep == 1'b1, "R9 asleep after mute", int'(asleep), 1);
        ticks_no_start(127, s);
        chk(asleep == 1'b1 && s == 0, "R9 still asleep at 127", int'(asleep), 1);
        tick_once();
        chk(asleep == 1'b0, "R9 awake at 128", int'(asleep), 0);
        measure(1000, n);
        chk(n == 151, "R9 counter held", n, 151);

        // R10: repeated mute restarts sleep
        do_reset(16'h00C8, 0);
        mute_en = 1'b1;
        ticks_no_start(10, s);
        pulse(1);
        ticks_no_start(100, s);
        pulse(1);
        ticks_no_start(127, s);
        chk(asleep == 1'b1, "R10 restarted sleep", int'(asleep), 1);
        tick_once();
        chk(asleep == 1'b0, "R10 restart ends at 128", int'(asleep), 0);

        // R11: wake ends sleep, beats mute
        do_reset(16'h00C8, 0);
        mute_en = 1'b1;
        ticks_no_start(10, s);
        pulse(1);
        ticks_no_start(5, s);
        pulse(2);
        chk(asleep == 1'b0, "R11 wake", int'(asleep), 0);
        pulse(1);
        chk(asleep == 1'b1, "R11 asleep again", int'(asleep), 1);
        pulse(3);
        chk(asleep == 1'b0, "R11 wake beats mute", int'(asleep), 0);
        measure(1000, n);
        chk(n == 191, "R11 counter kept", n, 191);

        // R12: mute disabled, and mute during transmission
        do_reset(16'h00C8, 0);
        mute_en = 1'b0;
        ticks_no_start(20, s);
        pulse(1);
        chk(asleep == 1'b0, "R12 mute disabled", int'(asleep), 0);
        measure(1000, n);
        chk(n == 181, "R12 counter unaffected", n, 181);
        mute_en = 1'b1;
        pulse(1);
        chk(asleep == 1'b0, "R12 mute during XMIT", int'(asleep), 0);
        pulse(4);
        chk(asleep == 1'b0, "R12 still awake after done", int'(asleep), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule